// File: doc/BRIEF.md
# Brown-out Reset Sequencer

This block decides when a microcontroller core may leave reset after power comes up, or after the supply sags below the brown-out threshold. A digital power-good level from an external comparator is synchronized into the clock domain. While that level is low, the core is kept in reset and its clock is held. Once the level is steady high, the sequencer works through a fixed order of waits, all counted in clock cycles. It first waits out a regulator settling interval. It then waits for the oscillator start-up timer (crystal modes only) and, when the PLL is in use, for the PLL lock flag. It also waits for the power-up timer. The core clock is let through once the clock source is ready, and the core reset is released once the power-up timer has also finished.

When a crystal is selected with a zero-length power-up timer, one fixed fail-safe delay replaces the whole wait. The sequencer also keeps a sticky brown-out flag. The flag is set on every loss of power-good and is cleared only by a software clear strobe or by power-on reset. Brown-out monitoring stays active in every state, including normal running, so it covers sleep and idle as well.

Top module: `bor_seq`

## Requirements
- R1: While `porN` is low, and right after it rises, `coreRst`=1, `clkHold`=1, `ostEn`=0 and `borFlag`=0.
- R2: `pwrGood` passes through a 2-flop synchronizer. A drop is seen as `coreRst`=1 and `clkHold`=1 in the second cycle after the drop, and never in the first. Any drop restarts the sequence at the start-up stage, and timing is then counted from the next rise.
- R3: After the synchronized power-good goes high, the block spends exactly START_CYCLES cycles in the start-up stage. During that stage `coreRst` stays 1.
- R4: The `oscMode` encoding is 00 internal RC, 01 external clock, 10 low-speed crystal, 11 high-speed crystal. When bit 1 is set (crystal) and the fail-safe case does not apply, `ostEn` is high for exactly OST_CYCLES cycles after start-up, and the clock is held until then. Otherwise `ostEn` stays 0.
- R5: When `pllEn`=1 and the fail-safe case does not apply, `clkHold` stays 1 until `pllLock` has been seen at 1. It falls one cycle after the later of the oscillator-timer end and the lock.
- R6: The power-up timer length is set by `pwrtSel`: 0 gives 0 cycles, 1 gives PWRT_BASE, 2 gives 2*PWRT_BASE and 3 gives 4*PWRT_BASE. `coreRst` falls at cycle START_CYCLES+max(C,P)+3 after `pwrGood` rises, where C is the clock-ready count and P is the timer length.
- R7: When `pwrtSel`=0 and a crystal is selected, the fail-safe delay applies. `clkHold` and `coreRst` both fall at cycle START_CYCLES+FSCM_CYCLES+3, whatever the settings of `pllEn` and `pllLock`, and `ostEn` stays 0.
- R8: `clkHold` is never 1 while `coreRst` is 0.
- R9: `borFlag` is set in the third cycle after any `pwrGood` drop. This holds in every stage, including normal running.
- R10: `borFlag` is not cleared by the reset sequence it started. A `statusClr` pulse clears it. If a set and a clear land in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| porN | input | 1 | Power-on reset, asynchronous, active low |
| pwrGood | input | 1 | Asynchronous supply-good level from the comparator |
| oscMode | input | 2 | Oscillator mode (bit 1 = crystal) |
| pllEn | input | 1 | PLL is in the clock path |
| pllLock | input | 1 | PLL lock flag |
| pwrtSel | input | 2 | Power-up timer length select |
| statusClr | input | 1 | Software clear strobe for the brown-out flag |
| coreRst | output | 1 | Core reset, active high |
| clkHold | output | 1 | Hold the system clock, active high |
| ostEn | output | 1 | Oscillator start-up timer running |
| borFlag | output | 1 | Sticky brown-out status |

## Verification
Every release time is counted from the `pwrGood` rise, which is driven on a falling clock edge. The two synchronizer flops add two cycles. The start-up stage adds START_CYCLES. The output register adds one more cycle after the last wait ends, which gives `clkHold` at START_CYCLES+C+3 and `coreRst` at START_CYCLES+R+3.

The bench samples every falling edge and records the first cycle in which each output drops. It compares these cycles with the arithmetic values for all oscillator modes, PLL settings, lock delays and timer lengths. It drives PLL lock on the falling edge after cycle START_CYCLES+2+L, so that the lock counts from cycle L of the wait stage. Brown-out effects are checked at the exact cycles after the drop: reset at the second, flag at the third.

// File: rtl/bor_seq_pkg.sv
package bor_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_START = 2'd0,
    SEQ_WAIT  = 2'd1,
    SEQ_RUN   = 2'd2
  } seqStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic cntInc;
    logic cntClr;
    logic flagSet;
  } seqStrobeT;

endpackage

// File: rtl/bor_seq_datapath.sv
module bor_seq_datapath
  import bor_seq_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int START_CYCLES = 20,
  parameter int OST_CYCLES   = 24,
  parameter int PWRT_BASE    = 8,
  parameter int FSCM_CYCLES  = 100
) (
  input  logic      clk,
  input  logic      porN,
  input  logic      pwrGood,
  input  logic [1:0] oscMode,
  input  logic [1:0] pwrtSel,
  input  logic      statusClr,
  input  seqStrobeT strobe,
  output logic      pgSync,
  output logic      pgFell,
  output logic      startDone,
  output logic      ostDone,
  output logic      pwrtDone,
  output logic      crystal,
  output logic      failSafe,
  output logic      borFlag
);

  localparam int PWRT_MAX_I = 4 * PWRT_BASE;
  localparam int TOP_A = (START_CYCLES > OST_CYCLES) ? START_CYCLES : OST_CYCLES;
  localparam int TOP_B = (PWRT_MAX_I > FSCM_CYCLES) ? PWRT_MAX_I : FSCM_CYCLES;
  localparam int CNT_TOP_I = (TOP_A > TOP_B) ? TOP_A : TOP_B;
  localparam int CNT_W = $clog2(CNT_TOP_I + 1);
  localparam logic [CNT_W-1:0] CNT_TOP   = CNT_W'(CNT_TOP_I);
  localparam logic [CNT_W-1:0] START_END = CNT_W'(START_CYCLES - 1);
  localparam logic [CNT_W-1:0] OST_END   = CNT_W'(OST_CYCLES);
  localparam logic [CNT_W-1:0] FSCM_END  = CNT_W'(FSCM_CYCLES);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   pgPrev;
  logic [CNT_W-1:0]       seqCnt;
  logic [CNT_W-1:0]       pwrtLen;
  logic [CNT_W-1:0]       pwrtTarget;

  // supply-good synchronizer
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      syncQ  <= '0;
      pgPrev <= 1'b0;
    end else begin
      syncQ  <= {syncQ[SYNC_STAGES-2:0], pwrGood};
      pgPrev <= syncQ[SYNC_STAGES-1];
    end
  end

  assign pgSync = syncQ[SYNC_STAGES-1];
  assign pgFell = pgPrev & ~pgSync;

  // shared stage counter, saturating
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      seqCnt <= '0;
    end else if (strobe.cntClr) begin
      seqCnt <= '0;
    end else if (strobe.cntInc && (seqCnt != CNT_TOP)) begin
      seqCnt <= seqCnt + 1'b1;
    end
  end

  always_comb begin
    case (pwrtSel)
      2'd0:    pwrtLen = '0;
      2'd1:    pwrtLen = CNT_W'(PWRT_BASE);
      2'd2:    pwrtLen = CNT_W'(2 * PWRT_BASE);
      default: pwrtLen = CNT_W'(4 * PWRT_BASE);
    endcase
  end

  assign crystal    = oscMode[1];
  assign failSafe   = crystal && (pwrtSel == 2'd0);
  assign pwrtTarget = failSafe ? FSCM_END : pwrtLen;
  assign startDone  = (seqCnt == START_END);
  assign ostDone    = (seqCnt >= OST_END);
  assign pwrtDone   = (seqCnt >= pwrtTarget);

  // sticky brown-out flag, set wins over clear
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      borFlag <= 1'b0;
    end else if (strobe.flagSet) begin
      borFlag <= 1'b1;
    end else if (statusClr) begin
      borFlag <= 1'b0;
    end
  end

  // R2: a supply loss empties the stage counter on the next edge
  a_r2_cnt_cleared : assert property (@(posedge clk) disable iff (!porN)
    !pgSync |=> (seqCnt == '0));

  // R9: every loss of synchronized supply-good sets the flag
  a_r9_flag_set : assert property (@(posedge clk) disable iff (!porN)
    $fell(pgSync) |=> borFlag);

  // R10: flag only drops through the clear strobe
  a_r10_flag_sticky : assert property (@(posedge clk) disable iff (!porN)
    (borFlag && !statusClr) |=> borFlag);

endmodule

// File: rtl/bor_seq_control.sv
module bor_seq_control
  import bor_seq_pkg::*;
(
  input  logic      clk,
  input  logic      porN,
  input  logic      pgSync,
  input  logic      pgFell,
  input  logic      startDone,
  input  logic      ostDone,
  input  logic      pwrtDone,
  input  logic      crystal,
  input  logic      failSafe,
  input  logic      pllEn,
  input  logic      pllLock,
  output seqStrobeT strobe,
  output logic      coreRst,
  output logic      clkHold,
  output logic      ostEn
);

  seqStateT state;
  seqStateT stateNext;
  logic     holdQ;
  logic     clockOk;
  logic     releaseOk;

  // clock source ready: fail-safe delay replaces the oscillator and PLL waits
  assign clockOk   = failSafe ? pwrtDone
                              : ((!crystal || ostDone) && (!pllEn || pllLock));
  assign releaseOk = clockOk && pwrtDone;

  always_comb begin
    strobe         = '0;
    strobe.flagSet = pgFell;
    stateNext      = state;
    if (!pgSync) begin
      strobe.cntClr = 1'b1;
      stateNext     = SEQ_START;
    end else begin
      case (state)
        SEQ_START: begin
          if (startDone) begin
            strobe.cntClr = 1'b1;
            stateNext     = SEQ_WAIT;
          end else begin
            strobe.cntInc = 1'b1;
          end
        end
        SEQ_WAIT: begin
          strobe.cntInc = 1'b1;
          if (releaseOk) stateNext = SEQ_RUN;
        end
        SEQ_RUN:  stateNext = SEQ_RUN;
        default:  stateNext = SEQ_START;
      endcase
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      state <= SEQ_START;
      holdQ <= 1'b1;
    end else begin
      state <= stateNext;
      holdQ <= !(pgSync && ((state == SEQ_RUN) ||
                            ((state == SEQ_WAIT) && clockOk)));
    end
  end

  assign coreRst = (state != SEQ_RUN) || !pgSync;
  assign clkHold = holdQ || !pgSync;
  assign ostEn   = pgSync && (state == SEQ_WAIT) && crystal && !failSafe && !ostDone;

  // R2: lost supply forces the start-up stage
  a_r2_restart : assert property (@(posedge clk) disable iff (!porN)
    !pgSync |=> (state == SEQ_START));

  // R3: start-up stage never releases the core
  a_r3_start_in_reset : assert property (@(posedge clk) disable iff (!porN)
    (state == SEQ_START) |-> coreRst);

  // R4: oscillator timer runs only while the core is still in reset
  a_r4_ost_in_reset : assert property (@(posedge clk) disable iff (!porN)
    ostEn |-> coreRst);

  // R5: an unlocked PLL keeps the clock held
  a_r5_pll_hold : assert property (@(posedge clk) disable iff (!porN)
    (pgSync && (state == SEQ_WAIT) && pllEn && !pllLock && !failSafe) |=> clkHold);

  // R8: clock runs before reset is released
  a_r8_order : assert property (@(posedge clk) disable iff (!porN)
    !coreRst |-> !clkHold);

endmodule

// File: rtl/bor_seq.sv
module bor_seq
  import bor_seq_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int START_CYCLES = 20,
  parameter int OST_CYCLES   = 24,
  parameter int PWRT_BASE    = 8,
  parameter int FSCM_CYCLES  = 100
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       pwrGood,
  input  logic [1:0] oscMode,
  input  logic       pllEn,
  input  logic       pllLock,
  input  logic [1:0] pwrtSel,
  input  logic       statusClr,
  output logic       coreRst,
  output logic       clkHold,
  output logic       ostEn,
  output logic       borFlag
);

  seqStrobeT strobe;
  logic pgSync, pgFell, startDone, ostDone, pwrtDone, crystal, failSafe;

  bor_seq_datapath #(
    .SYNC_STAGES (SYNC_STAGES),
    .START_CYCLES(START_CYCLES),
    .OST_CYCLES  (OST_CYCLES),
    .PWRT_BASE   (PWRT_BASE),
    .FSCM_CYCLES (FSCM_CYCLES)
  ) i_datapath (
    .clk      (clk),
    .porN     (porN),
    .pwrGood  (pwrGood),
    .oscMode  (oscMode),
    .pwrtSel  (pwrtSel),
    .statusClr(statusClr),
    .strobe   (strobe),
    .pgSync   (pgSync),
    .pgFell   (pgFell),
    .startDone(startDone),
    .ostDone  (ostDone),
    .pwrtDone (pwrtDone),
    .crystal  (crystal),
    .failSafe (failSafe),
    .borFlag  (borFlag)
  );

  bor_seq_control i_control (
    .clk      (clk),
    .porN     (porN),
    .pgSync   (pgSync),
    .pgFell   (pgFell),
    .startDone(startDone),
    .ostDone  (ostDone),
    .pwrtDone (pwrtDone),
    .crystal  (crystal),
    .failSafe (failSafe),
    .pllEn    (pllEn),
    .pllLock  (pllLock),
    .strobe   (strobe),
    .coreRst  (coreRst),
    .clkHold  (clkHold),
    .ostEn    (ostEn)
  );

endmodule

// File: tb/test_bor_seq.sv
`timescale 1ns/1ps
module test_bor_seq;

  localparam int START_C = 20;
  localparam int OST_C   = 24;
  localparam int BASE_C  = 8;
  localparam int FSCM_C  = 100;
  localparam int RUN_LEN = 140;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic pwrGood = 1'b0;
  logic [1:0] oscMode = 2'd0;
  logic pllEn = 1'b0;
  logic pllLock = 1'b0;
  logic [1:0] pwrtSel = 2'd0;
  logic statusClr = 1'b0;
  logic coreRst, clkHold, ostEn, borFlag;

  int testCnt = 0;
  int failCnt = 0;

  always #2 clk = ~clk;

  bor_seq #(
    .SYNC_STAGES(2), .START_CYCLES(START_C), .OST_CYCLES(OST_C),
    .PWRT_BASE(BASE_C), .FSCM_CYCLES(FSCM_C)
  ) i_bor_seq (
    .clk(clk), .porN(porN), .pwrGood(pwrGood), .oscMode(oscMode),
    .pllEn(pllEn), .pllLock(pllLock), .pwrtSel(pwrtSel),
    .statusClr(statusClr), .coreRst(coreRst), .clkHold(clkHold),
    .ostEn(ostEn), .borFlag(borFlag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // one full sequence from a supply rise, release cycles measured in falling edges
  task automatic runSeq(input int osc, input int pll, input int pwrt, input int lk);
    int firstRst = -1;
    int firstHold = -1;
    int ostHigh = 0;
    int rstAtStartEnd = 0;
    int o, p, c, r;
    bit fs;
    @(negedge clk);
    pwrGood = 1'b0; pllLock = 1'b0;
    oscMode = osc[1:0]; pllEn = pll[0]; pwrtSel = pwrt[1:0];
    repeat (4) @(negedge clk);
    pwrGood = 1'b1;
    for (int n = 1; n <= RUN_LEN; n++) begin
      @(negedge clk);
      if (coreRst == 1'b0 && firstRst < 0) firstRst = n;
      if (clkHold == 1'b0 && firstHold < 0) firstHold = n;
      if (ostEn) ostHigh++;
      if (n == START_C + 2) rstAtStartEnd = coreRst;
      if (pll != 0 && n == 2 + START_C + lk) pllLock = 1'b1;
    end
    fs = (osc >= 2) && (pwrt == 0);
    o  = (osc >= 2) ? OST_C : 0;
    p  = (pwrt == 0) ? 0 : (BASE_C << (pwrt - 1));
    c  = fs ? FSCM_C : maxOf(o, (pll != 0) ? lk : 0);
    r  = fs ? FSCM_C : maxOf(c, p);
    check(rstAtStartEnd == 1, "R3 reset held through start-up", rstAtStartEnd, 1);
    check(firstRst == START_C + r + 3, fs ? "R7 fail-safe reset release" : "R6 reset release cycle",
          firstRst, START_C + r + 3);
    check(firstHold == START_C + c + 3,
          fs ? "R7 fail-safe clock release" : ((pll != 0) ? "R5 clock release with PLL" : "R4 clock release"),
          firstHold, START_C + c + 3);
    check(ostHigh == ((osc >= 2 && !fs) ? OST_C : 0), "R4 oscillator timer length",
          ostHigh, (osc >= 2 && !fs) ? OST_C : 0);
    check(firstHold >= 0 && firstHold <= firstRst, "R8 clock before reset", firstHold, firstRst);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failCnt++;
    testCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin : main
    int firstRst;
    // R1 reset state
    repeat (3) @(negedge clk);
    check(coreRst && clkHold && !ostEn && !borFlag, "R1 state in reset",
          {coreRst, clkHold, ostEn, borFlag}, 4'b1100);
    porN = 1'b1;
    repeat (3) @(negedge clk);
    check(coreRst && clkHold && !ostEn && !borFlag, "R1 state after reset",
          {coreRst, clkHold, ostEn, borFlag}, 4'b1100);

    // sweep every mode, PLL setting, lock delay and timer length
    for (int osc = 0; osc < 4; osc++)
      for (int pwrt = 0; pwrt < 4; pwrt++)
        for (int pll = 0; pll < 2; pll++)
          for (int li = 0; li < ((pll != 0) ? 3 : 1); li++)
            runSeq(osc, pll, pwrt, (li == 0) ? 0 : ((li == 1) ? 10 : 40));

    // brown-out while running
    @(negedge clk); statusClr = 1'b1;
    @(negedge clk); statusClr = 1'b0;
    check(borFlag == 1'b0, "R10 clear strobe clears flag", borFlag, 0);
    check(coreRst == 1'b0, "R2 running before drop", coreRst, 0);
    pwrGood = 1'b0;
    @(negedge clk);
    check(coreRst == 1'b0, "R2 no reset in first cycle", coreRst, 0);
    @(negedge clk);
    check(coreRst && clkHold, "R2 reset and hold in second cycle", {coreRst, clkHold}, 2'b11);
    check(borFlag == 1'b0, "R9 flag not yet set", borFlag, 0);
    @(negedge clk);
    check(borFlag == 1'b1, "R9 flag set while running", borFlag, 1);

    // glitch during start-up restarts the sequence: internal RC, no PLL, pwrtSel=1
    oscMode = 2'd0; pllEn = 1'b0; pwrtSel = 2'd1;
    statusClr = 1'b1;
    @(negedge clk); statusClr = 1'b0;
    repeat (3) @(negedge clk);
    pwrGood = 1'b1;
    repeat (10) @(negedge clk);
    pwrGood = 1'b0;
    @(negedge clk);
    pwrGood = 1'b1;
    firstRst = -1;
    for (int n = 1; n <= RUN_LEN; n++) begin
      @(negedge clk);
      if (coreRst == 1'b0 && firstRst < 0) firstRst = n;
    end
    check(firstRst == START_C + BASE_C + 3, "R2 restart after glitch", firstRst, START_C + BASE_C + 3);
    check(borFlag == 1'b1, "R9 glitch sets flag", borFlag, 1);
    check(borFlag == 1'b1, "R10 flag survives its reset sequence", borFlag, 1);
    @(negedge clk); statusClr = 1'b1;
    @(negedge clk); statusClr = 1'b0;
    check(borFlag == 1'b0, "R10 clear after sequence", borFlag, 0);

    // set wins over clear in the same cycle
    pwrGood = 1'b0;
    repeat (2) @(negedge clk);
    statusClr = 1'b1;
    @(negedge clk);
    statusClr = 1'b0;
    check(borFlag == 1'b1, "R10 set wins over clear", borFlag, 1);

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule